// File: doc/BRIEF.md
# Sigma-Delta Fractional Divide Controller

This block supplies a fractional-N feedback divider with one integer divide value per comparison cycle. It holds a programmed integer part and a signed fractional word and runs a third-order cascade of three modulus-62976 accumulators. The carries of these accumulators are combined into a small signed offset that dithers the divide value from cycle to cycle. Over time the average divide ratio equals the integer part plus the fraction divided by 62976. The fraction is centred on zero and can reach about half a step either side of the integer.

The divide values leave the block as a valid/ready stream. The downstream pulse-swallow counter asserts `div_ready` when it takes a value, which is normally once per reference cycle. A handshake (`div_valid` and `div_ready` both high at a rising edge) consumes the presented value and moves the modulator one step forward. While `div_ready` is low, the presented value, the modulator state and the configuration the block is using all stay frozen. `div_valid` drops only for the single cycle that follows a reset or a counter-clear command. The configuration inputs are plain level signals. They are sampled only when a stream value is consumed, and when the block re-primes after a clear, so a change in configuration always takes effect on a cycle boundary. A select input bypasses the modulator for integer-only operation.

Top module: `frac_div_ctrl`

## Requirements
- R1: While `rst` is high, `div_valid` is low. `div_valid` stays low for the first cycle after `rst` falls. At the next rising edge the block samples the configuration inputs and raises `div_valid`.
- R2: When the sampled fractional-select bit is low, `div_value` equals the sampled integer part and `div_offset` is 0, whatever the fraction input holds.
- R3: `cfg_frac` is a 17-bit two's-complement word F. For F below zero, the modulator runs on F+62976 and the integer base is lowered by one. In every mode `div_value` = integer part + `div_offset`.
- R4: Fraction codes above +31488 act as +31488, and codes below -31488 act as -31488.
- R5: `div_offset` always lies in the range -4 to +4.
- R6: Take 62976 consecutive handshakes that start from a clear, with the configuration held constant. The sum of `div_offset` over them is within 3 of the effective (saturated) F.
- R7: At each step, accumulator 1 adds U (the folded fraction), accumulator 2 adds the new residue of accumulator 1, and accumulator 3 adds the new residue of accumulator 2. Each accumulator works modulo 62976 and its carry is 1 when its sum reaches 62976. The offset is c1 + c2 - c2' + c3 - 2*c3' + c3'' - neg. Here ' marks the previous step and '' the step before it, both 0 after a clear, and neg is 1 for negative F. The first value after a clear is therefore the integer part minus neg.
- R8: While `div_ready` is low, the presented value is held and the modulator does not advance. The next handshake continues the sequence from where it stopped.
- R9: Configuration changes made between handshakes have no effect on the presented value until the next handshake or re-prime.
- R10: A `cnt_clear` pulse empties all accumulators and carry history and drops `div_valid` for one cycle. The block then re-primes with the current configuration.
- R11: While integer mode is in use, the accumulators are emptied at every handshake. Enabling the fraction again therefore restarts the sequence at its first value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_frac_en | input | 1 | Fractional mode select (1 = modulator on) |
| cfg_n_int | input | NW | Integer part of the divide ratio |
| cfg_frac | input | FW | Signed fractional word, two's complement |
| cnt_clear | input | 1 | Counter-clear command, synchronous |
| div_valid | output | 1 | A divide value is presented |
| div_ready | input | 1 | Consumer takes the presented value |
| div_value | output | NW | Divide value for the current cycle |
| div_offset | output | 4 | Signed offset of div_value from the integer part |

## Verification
The bench uses the default parameters: a 62976 modulus, a 10-bit integer part and a 17-bit fraction word. These defaults let two complete modulus windows of handshakes fit in one run, so the window-sum bound can be checked both for a negative fraction near -0.47 and for a saturated code of +40000. A 17-bit word can hold the raw codes ±40000, which makes the saturation corner reachable from the port. A second-value check separates a saturated -40000 from an unsaturated one. An integer-based model of the cascade is compared against every presented value throughout both windows.

// File: rtl/sdm_pkg.sv
`timescale 1ns/1ps
package sdm_pkg;
  // Number of cascaded accumulators; the cancellation network is written for three.
  localparam int SDM_ORDER = 3;
  // Offset from the integer part; the range -4..+4 fits in four signed bits.
  typedef logic signed [3:0] offset_t;
endpackage

// File: rtl/sdm_frac_fold.sv
`timescale 1ns/1ps
// Saturates the signed fraction to +/- MOD/2 and folds it into an unsigned
// accumulator step plus a flag that lowers the integer base by one.
module sdm_frac_fold #(
  parameter int FW    = 17,
  parameter int MOD   = 62976,
  parameter int ACC_W = 16
) (
  input  logic signed [FW-1:0] frac,
  output logic [ACC_W-1:0]     step,
  output logic                 neg
);
  localparam int LIM = MOD / 2;

  int fs;

  always_comb begin
    fs = int'(frac);
    if (fs > LIM)       fs = LIM;
    else if (fs < -LIM) fs = -LIM;
    neg  = (fs < 0);
    step = ACC_W'((fs < 0) ? (fs + MOD) : fs);
  end
endmodule

// File: rtl/sdm_mod_acc.sv
`timescale 1ns/1ps
// One modulus accumulator stage: it owns its residue register and shows the
// carry and next residue for the step now being presented.
module sdm_mod_acc #(
  parameter int MOD   = 62976,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] res_next,
  output logic             carry
);
  localparam logic [ACC_W:0] MODV = (ACC_W+1)'(MOD);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   wrapped;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, addend};
    carry    = (sum >= MODV);
    wrapped  = carry ? (sum - MODV) : sum;
    res_next = wrapped[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc_q <= '0;
    else if (adv)    acc_q <= res_next;
  end

  // R7: the stored residue never leaves 0..MOD-1
  a_r7_residue_bound: assert property (@(posedge clk) disable iff (rst)
    acc_q < MODV);
endmodule

// File: rtl/sdm_cancel.sv
`timescale 1ns/1ps
// Cancellation network: differentiates the second and third carries against
// their own history and sums everything into the signed per-step offset.
module sdm_cancel
  import sdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       adv,
  input  logic [2:0] cy,
  input  logic       neg,
  output offset_t    off
);
  logic c2d, c3d, c3dd;
  logic signed [4:0] y;

  always_comb begin
    y = $signed({4'b0, cy[0]})
      + $signed({4'b0, cy[1]}) - $signed({4'b0, c2d})
      + $signed({4'b0, cy[2]}) - $signed({3'b0, c3d, 1'b0}) + $signed({4'b0, c3dd})
      - $signed({4'b0, neg});
    off = y[3:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c2d  <= 1'b0;
      c3d  <= 1'b0;
      c3dd <= 1'b0;
    end else if (adv) begin
      c2d  <= cy[1];
      c3dd <= c3d;
      c3d  <= cy[2];
    end
  end

  // R5: offset confined to -4..+4
  a_r5_offset_range: assert property (@(posedge clk) disable iff (rst)
    (off >= -4) && (off <= 4));
endmodule

// File: rtl/frac_div_ctrl.sv
`timescale 1ns/1ps
module frac_div_ctrl
  import sdm_pkg::*;
#(
  parameter int NW  = 10,
  parameter int FW  = 17,
  parameter int MOD = 62976
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_frac_en,
  input  logic [NW-1:0]        cfg_n_int,
  input  logic signed [FW-1:0] cfg_frac,
  input  logic                 cnt_clear,
  output logic                 div_valid,
  input  logic                 div_ready,
  output logic [NW-1:0]        div_value,
  output logic signed [3:0]    div_offset
);
  localparam int ACC_W = $clog2(MOD);
  localparam int ORDER = SDM_ORDER;

  // Shadow configuration, taken only on a handshake or when re-priming.
  logic                 primed;
  logic                 en_q;
  logic [NW-1:0]        n_q;
  logic signed [FW-1:0] frac_q;

  logic fire;
  logic st_adv;
  logic st_clr;

  logic [ACC_W-1:0] step;
  logic             neg;
  logic [ACC_W-1:0] res_nx [ORDER];
  logic [ACC_W-1:0] addend [ORDER];
  logic [ORDER-1:0] cy;
  offset_t          mod_off;
  logic signed [NW+1:0] sum_w;

  assign fire   = primed && div_ready;
  assign st_adv = fire && en_q;
  assign st_clr = cnt_clear || (fire && !en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      en_q   <= 1'b0;
      n_q    <= '0;
      frac_q <= '0;
    end else if (cnt_clear) begin
      primed <= 1'b0;
    end else if (!primed || fire) begin
      primed <= 1'b1;
      en_q   <= cfg_frac_en;
      n_q    <= cfg_n_int;
      frac_q <= cfg_frac;
    end
  end

  sdm_frac_fold #(.FW(FW), .MOD(MOD), .ACC_W(ACC_W)) u_fold (
    .frac (frac_q),
    .step (step),
    .neg  (neg)
  );

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign addend[k] = step;
    end else begin : g_chain
      assign addend[k] = res_nx[k-1];
    end
    sdm_mod_acc #(.MOD(MOD), .ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .clr      (st_clr),
      .adv      (st_adv),
      .addend   (addend[k]),
      .res_next (res_nx[k]),
      .carry    (cy[k])
    );
  end

  sdm_cancel u_cancel (
    .clk (clk),
    .rst (rst),
    .clr (st_clr),
    .adv (st_adv),
    .cy  (cy),
    .neg (neg),
    .off (mod_off)
  );

  always_comb begin
    div_valid  = primed;
    div_offset = en_q ? mod_off : 4'sd0;
    sum_w      = $signed({2'b00, n_q}) + (NW+2)'(div_offset);
    div_value  = sum_w[NW-1:0];
  end

  // R10: a clear command always withdraws the stream for a cycle
  a_r10_clear_drops_valid: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> !div_valid);

  // R8: a stalled value is held unchanged
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (div_valid && !div_ready && !cnt_clear) |=>
      (div_valid && $stable(div_value) && $stable(div_offset)));

  // R2: integer mode presents no offset
  a_r2_int_no_offset: assert property (@(posedge clk) disable iff (rst)
    (div_valid && !en_q) |-> (div_offset == 4'sd0));
endmodule

// File: tb/sim_frac_div_ctrl.sv
`timescale 1ns/1ps
module sim_frac_div_ctrl;
  localparam int NW  = 10;
  localparam int FW  = 17;
  localparam int MOD = 62976;
  localparam int LIM = MOD / 2;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_frac_en = 1'b0;
  logic [NW-1:0] cfg_n_int = '0;
  logic signed [FW-1:0] cfg_frac = '0;
  logic cnt_clear = 1'b0;
  logic div_ready = 1'b0;
  logic div_valid;
  logic [NW-1:0] div_value;
  logic signed [3:0] div_offset;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  frac_div_ctrl #(.NW(NW), .FW(FW), .MOD(MOD)) u0 (
    .clk(clk), .rst(rst), .cfg_frac_en(cfg_frac_en), .cfg_n_int(cfg_n_int),
    .cfg_frac(cfg_frac), .cnt_clear(cnt_clear), .div_valid(div_valid),
    .div_ready(div_ready), .div_value(div_value), .div_offset(div_offset)
  );

  // Stimulus: {frac_en, n_int, frac, first value, second value}
  typedef struct packed { logic en; int n; int f; int d0; int d1; } vec_t;
  localparam vec_t VECS [7] = '{
    '{1'b0, 300,  12345, 300, 300},  // R2 fraction ignored
    '{1'b1,  97,   3456,  97,  97},  // R7 small positive fraction
    '{1'b1,  99, -29760,  98, 100},  // R3 negative fold
    '{1'b1,  50,  40000,  50,  52},  // R4 positive saturation
    '{1'b1,  60, -40000,  59,  61},  // R4 negative saturation
    '{1'b1,  80,     -1,  79,  82},  // R5 large positive offset
    '{1'b1,  72,      0,  72,  72}   // R3 zero fraction
  };

  // Reference model of the cascade, integer arithmetic.
  int m_u, m_neg, m_c2d, m_c3d, m_c3dd;
  int m_a [3];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int sat(input int f);
    return (f > LIM) ? LIM : ((f < -LIM) ? -LIM : f);
  endfunction

  task automatic model_load(input int f);
    int fs;
    fs = sat(f);
    m_neg = (fs < 0) ? 1 : 0;
    m_u   = (fs < 0) ? fs + MOD : fs;
    m_a   = '{0, 0, 0};
    m_c2d = 0; m_c3d = 0; m_c3dd = 0;
  endtask

  task automatic model_next(output int off);
    int c [3];
    int in;
    int s;
    in = m_u;
    for (int k = 0; k < 3; k++) begin
      s = m_a[k] + in;
      c[k] = (s >= MOD) ? 1 : 0;
      m_a[k] = (s >= MOD) ? s - MOD : s;
      in = m_a[k];
    end
    off = c[0] + c[1] - m_c2d + c[2] - 2 * m_c3d + m_c3dd - m_neg;
    m_c3dd = m_c3d;
    m_c3d  = c[2];
    m_c2d  = c[1];
  endtask

  // Clear, then re-prime with the given configuration; ready stays low.
  task automatic do_load(input logic en, input int n, input int f);
    cfg_frac_en = en;
    cfg_n_int   = NW'(n);
    cfg_frac    = FW'(f);
    div_ready   = 1'b0;
    cnt_clear   = 1'b1;
    tick();
    cnt_clear = 1'b0;
    check("R10 valid low after clear", int'(div_valid), 0);
    tick();
  endtask

  task automatic window(input int n, input int f);
    int sum;
    int bad;
    int off;
    sum = 0;
    bad = 0;
    do_load(1'b1, n, f);
    model_load(f);
    div_ready = 1'b1;
    for (int i = 0; i < MOD; i++) begin
      model_next(off);
      if (!div_valid || int'(div_offset) != off || int'(div_value) != n + off) bad++;
      sum += int'(div_offset);
      tick();
    end
    div_ready = 1'b0;
    check("R7 per-step mismatches vs model", bad, 0);
    checks++;
    if (sum > sat(f) + 3 || sum < sat(f) - 3) begin
      fails++;
      $display("FAIL R6 window sum actual=%0d expected=%0d+/-3", sum, sat(f));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog R6 actual=%0d cycles expected<%0d", cyc, WDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset and priming
    tick(); tick(); tick();
    check("R1 valid low in reset", int'(div_valid), 0);
    cfg_frac_en = 1'b0;
    cfg_n_int   = NW'(123);
    rst = 1'b0;
    check("R1 valid low right after release", int'(div_valid), 0);
    tick();
    check("R1 valid after priming", int'(div_valid), 1);
    check("R1 primed value", int'(div_value), 123);

    // Vector table: first and second values after a clear
    for (int v = 0; v < 7; v++) begin
      do_load(VECS[v].en, VECS[v].n, VECS[v].f);
      check($sformatf("R3 vec%0d valid", v), int'(div_valid), 1);
      check($sformatf("R7 vec%0d first value", v), int'(div_value), VECS[v].d0);
      check($sformatf("R3 vec%0d value=n+offset", v), int'(div_value),
            VECS[v].n + int'(div_offset));
      div_ready = 1'b1;
      tick();
      div_ready = 1'b0;
      check($sformatf("R4 vec%0d second value", v), int'(div_value), VECS[v].d1);
    end

    // R8: stall holds value and state
    do_load(1'b1, 80, -1);
    tick(); tick(); tick();
    check("R8 held value during stall", int'(div_value), 79);
    check("R8 valid during stall", int'(div_valid), 1);
    div_ready = 1'b1;
    tick();
    div_ready = 1'b0;
    check("R8 sequence resumes", int'(div_value), 82);

    // R9: config sampled only at a handshake
    do_load(1'b0, 300, 0);
    cfg_n_int = NW'(301);
    tick();
    check("R9 change ignored before handshake", int'(div_value), 300);
    div_ready = 1'b1;
    tick();
    div_ready = 1'b0;
    check("R9 change taken at handshake", int'(div_value), 301);

    // R11: leave and re-enter fractional mode
    do_load(1'b1, 80, -1);
    cfg_frac_en = 1'b0;
    div_ready = 1'b1;
    tick();
    check("R2 integer value after switch", int'(div_value), 80);
    check("R2 zero offset after switch", int'(div_offset), 0);
    cfg_frac_en = 1'b1;
    tick();
    check("R11 restart first value", int'(div_value), 79);
    tick();
    div_ready = 1'b0;
    check("R11 restart second value", int'(div_value), 82);

    // R6/R7: full modulus windows
    window(99, -29760);
    window(97, 40000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule